// File: doc/BRIEF.md
# Pipelined Iterative Threshold Decoder

This block decodes a length-7 cyclic majority-logic code. Each of the seven bits has three parity checks that are orthogonal on it (every other bit shares exactly one check with it). The code has 8 codewords. The input is a whole word of soft symbols, presented in parallel. The decoder runs a fixed number of soft-in/soft-out threshold iterations. Each iteration is unrolled into its own registered stage, so the block accepts a new word on every clock and returns one hard-decided word per input word.

Each stage works on the original received word. To it, the stage adds a weighted copy of the extrinsic estimate that the previous stage produced. The weight is a power of two, applied as a right shift, and the sum is clipped to the symbol range. For every check on a bit, the stage finds the two partner symbols and forms a min-sum term: the sign is the product of their signs and the magnitude is the smaller of their magnitudes. The three terms are added to give the new extrinsic estimate. The final stage adds that estimate to its own weighted input and takes the sign as the decoded bit.

The check sets for bit i, taken modulo 7, are {i+1, i+3}, {i+2, i+6} and {i+4, i+5}.

Top module: `iter_thresh_dec`

## Requirements
- R1: Symbol i occupies `in_sym[i*Q +: Q]`. Its top bit is the sign, where 1 means negative, which is hard bit 1. The remaining Q-1 bits are the magnitude, and a negative zero is treated as zero. Decoded bit i appears at `out_bits[i]`.
- R2: `out_valid` is `in_valid` delayed by exactly NITER clock cycles. A word may be offered on every cycle, and results leave in the order the words arrived.
- R3: A word whose sign bits form a codeword decodes to those sign bits, whatever its magnitudes. A word forms a codeword when, for every i, bits i, i+1 and i+3 (mod 7) have even parity.
- R4: A codeword with equal nonzero magnitudes and exactly one sign flipped decodes to the original codeword.
- R5: Each iteration works as follows:
  - The first iteration uses a zero prior.
  - Each check contributes the product of its two partner signs times the minimum of their magnitudes.
  - The extrinsic value of a bit is the sum of its three check contributions.
  - The last stage outputs 1 when the sum of the weighted input and the new extrinsic value is negative, and 0 when that sum is positive.
- R6: The prior extrinsic value is scaled by 2^-ASH with rounding toward zero. The result is added to the received value and saturated to ±(2^(Q-1)-1).
- R7: When the final sum of a bit is zero, the decoded bit equals the received sign. A word with every magnitude zero therefore returns its own sign bits.
- R8: While `out_valid` is low, `out_bits` keeps its previous value, and `in_sym` without `in_valid` has no effect.
- R9: While reset is asserted, `out_valid` and `out_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_sym` for this cycle |
| in_sym | input | 7*Q | Seven sign-magnitude soft symbols |
| out_valid | output | 1 | Qualifies `out_bits` |
| out_bits | output | 7 | Hard decoded word |

## Verification
Every decoded word is due exactly NITER rising edges after the edge that captured its input, and nothing else appears on the outputs in between. The bench stamps each accepted word with the edge count at which it was driven. It samples the outputs on the falling edge and requires each result to show up at exactly that count plus NITER, in arrival order. On every falling edge with no result, it checks that `out_bits` has not moved. The checker keeps its own NITER-deep copy of `in_valid`, of the input signs and of the codeword/erasure flags, so the timing and pass-through properties line up on the same edge.

// File: rtl/itd_pkg.sv
package itd_pkg;

    localparam int CODE_N = 7;
    localparam int CODE_J = 3;

    // Partner positions of bit_i within check chk (side 0 or 1), modulo CODE_N.
    function automatic int partner(input int bit_i, input int chk, input int side);
        int off;
        case (chk)
            0:       off = (side == 0) ? 1 : 3;
            1:       off = (side == 0) ? 2 : 6;
            default: off = (side == 0) ? 4 : 5;
        endcase
        return (bit_i + off) % CODE_N;
    endfunction

    // Signed width that holds the sum of CODE_J min-sum terms.
    function automatic int ext_width(input int q);
        return $clog2(CODE_J * ((1 << (q - 1)) - 1) + 1) + 1;
    endfunction

endpackage

// File: rtl/itd_scale.sv
// Weights the prior extrinsic word, adds the received word, saturates,
// and returns the result in sign-magnitude form.
module itd_scale
    import itd_pkg::*;
#(
    parameter int Q   = 5,
    parameter int WW  = 7,
    parameter int ASH = 1
) (
    input  logic [CODE_N*Q-1:0]  r_i,
    input  logic [CODE_N*WW-1:0] w_i,
    output logic [CODE_N*Q-1:0]  y_o
);
    localparam int MAXM = (1 << (Q - 1)) - 1;

    always_comb begin
        y_o = '0;
        for (int i = 0; i < CODE_N; i++) begin
            int rv;
            int wv;
            int wm;
            int yv;
            rv = int'(r_i[i*Q +: Q-1]);
            if (r_i[i*Q+Q-1]) rv = -rv;
            wv = int'($signed(w_i[i*WW +: WW]));
            wm = ((wv < 0) ? -wv : wv) >> ASH;
            yv = rv + ((wv < 0) ? -wm : wm);
            if (yv > MAXM)       yv = MAXM;
            else if (yv < -MAXM) yv = -MAXM;
            y_o[i*Q +: Q] = {yv < 0, (Q-1)'((yv < 0) ? -yv : yv)};
        end
    end

endmodule

// File: rtl/itd_ext.sv
// Min-sum extrinsic estimate for every bit over its orthogonal checks.
module itd_ext
    import itd_pkg::*;
#(
    parameter int Q  = 5,
    parameter int WW = 7
) (
    input  logic [CODE_N*Q-1:0]  y_i,
    output logic [CODE_N*WW-1:0] ext_o
);
    always_comb begin
        ext_o = '0;
        for (int i = 0; i < CODE_N; i++) begin
            int acc;
            acc = 0;
            for (int j = 0; j < CODE_J; j++) begin
                int a;
                int b;
                int ma;
                int mb;
                int mn;
                logic neg;
                a   = partner(i, j, 0);
                b   = partner(i, j, 1);
                ma  = int'(y_i[a*Q +: Q-1]);
                mb  = int'(y_i[b*Q +: Q-1]);
                mn  = (ma < mb) ? ma : mb;
                neg = y_i[a*Q+Q-1] ^ y_i[b*Q+Q-1];
                acc = acc + (neg ? -mn : mn);
            end
            ext_o[i*WW +: WW] = WW'(acc);
        end
    end

endmodule

// File: rtl/itd_stage.sv
// One unrolled intermediate iteration: registers the new extrinsic word
// together with the received word that it belongs to.
module itd_stage
    import itd_pkg::*;
#(
    parameter int Q   = 5,
    parameter int WW  = 7,
    parameter int ASH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [CODE_N*Q-1:0]  r_i,
    input  logic [CODE_N*WW-1:0] w_i,
    output logic                 vld_o,
    output logic [CODE_N*Q-1:0]  r_o,
    output logic [CODE_N*WW-1:0] w_o
);
    typedef struct packed {
        logic                 vld;
        logic [CODE_N*Q-1:0]  r;
        logic [CODE_N*WW-1:0] w;
    } st_t;

    st_t st_d, st_q;
    logic [CODE_N*Q-1:0]  y_w;
    logic [CODE_N*WW-1:0] ext_w;

    itd_scale #(.Q(Q), .WW(WW), .ASH(ASH)) u_scale (
        .r_i (r_i),
        .w_i (w_i),
        .y_o (y_w)
    );

    itd_ext #(.Q(Q), .WW(WW)) u_ext (
        .y_i   (y_w),
        .ext_o (ext_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.r = r_i;
            st_d.w = ext_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign r_o   = st_q.r;
    assign w_o   = st_q.w;

endmodule

// File: rtl/itd_final.sv
// Last iteration: new extrinsic estimate plus weighted input, then the
// sign decision (ties fall back to the received sign).
module itd_final
    import itd_pkg::*;
#(
    parameter int Q   = 5,
    parameter int WW  = 7,
    parameter int ASH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [CODE_N*Q-1:0]  r_i,
    input  logic [CODE_N*WW-1:0] w_i,
    output logic                 vld_o,
    output logic [CODE_N-1:0]    hard_o
);
    typedef struct packed {
        logic              vld;
        logic [CODE_N-1:0] hard;
    } st_t;

    st_t st_d, st_q;
    logic [CODE_N*Q-1:0]  y_w;
    logic [CODE_N*WW-1:0] ext_w;
    logic [CODE_N-1:0]    dec_w;

    itd_scale #(.Q(Q), .WW(WW), .ASH(ASH)) u_scale (
        .r_i (r_i),
        .w_i (w_i),
        .y_o (y_w)
    );

    itd_ext #(.Q(Q), .WW(WW)) u_ext (
        .y_i   (y_w),
        .ext_o (ext_w)
    );

    always_comb begin
        dec_w = '0;
        for (int i = 0; i < CODE_N; i++) begin
            int yv;
            int tv;
            yv = int'(y_w[i*Q +: Q-1]);
            if (y_w[i*Q+Q-1]) yv = -yv;
            tv = yv + int'($signed(ext_w[i*WW +: WW]));
            dec_w[i] = (tv < 0) | ((tv == 0) & r_i[i*Q+Q-1]);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.hard = dec_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign hard_o = st_q.hard;

endmodule

// File: rtl/iter_thresh_dec.sv
// Fully parallel iterative threshold decoder, one registered stage per
// iteration; accepts one word per clock, latency NITER.
module iter_thresh_dec
    import itd_pkg::*;
#(
    parameter int Q     = 5,
    parameter int NITER = 2,
    parameter int ASH   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CODE_N*Q-1:0] in_sym,
    output logic                out_valid,
    output logic [CODE_N-1:0]   out_bits
);
    localparam int WW = ext_width(Q);

    logic                 vld_c [NITER];
    logic [CODE_N*Q-1:0]  r_c   [NITER];
    logic [CODE_N*WW-1:0] w_c   [NITER];

    assign vld_c[0] = in_valid;
    assign r_c[0]   = in_sym;
    assign w_c[0]   = '0;

    for (genvar k = 0; k < NITER - 1; k++) begin : g_iter
        itd_stage #(.Q(Q), .WW(WW), .ASH(ASH)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_c[k]),
            .r_i   (r_c[k]),
            .w_i   (w_c[k]),
            .vld_o (vld_c[k+1]),
            .r_o   (r_c[k+1]),
            .w_o   (w_c[k+1])
        );
    end

    itd_final #(.Q(Q), .WW(WW), .ASH(ASH)) u_final (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_c[NITER-1]),
        .r_i    (r_c[NITER-1]),
        .w_i    (w_c[NITER-1]),
        .vld_o  (out_valid),
        .hard_o (out_bits)
    );

endmodule

// File: rtl/itd_chk.sv
module itd_chk
    import itd_pkg::*;
#(
    parameter int Q     = 5,
    parameter int NITER = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CODE_N*Q-1:0] in_sym,
    input logic                out_valid,
    input logic [CODE_N-1:0]   out_bits
);
    logic [CODE_N-1:0] sgn;
    logic              is_cw;
    logic              all_zero;

    always_comb begin
        is_cw    = 1'b1;
        all_zero = 1'b1;
        for (int i = 0; i < CODE_N; i++) begin
            sgn[i] = in_sym[i*Q+Q-1];
            if (in_sym[i*Q +: Q-1] != '0) all_zero = 1'b0;
        end
        for (int i = 0; i < CODE_N; i++)
            for (int j = 0; j < CODE_J; j++)
                if (sgn[i] ^ sgn[partner(i, j, 0)] ^ sgn[partner(i, j, 1)]) is_cw = 1'b0;
    end

    logic [NITER-1:0]  v_sh;
    logic [NITER-1:0]  c_sh;
    logic [NITER-1:0]  z_sh;
    logic [CODE_N-1:0] s_sh [NITER];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_sh <= '0;
            c_sh <= '0;
            z_sh <= '0;
            for (int k = 0; k < NITER; k++) s_sh[k] <= '0;
        end else begin
            v_sh[0] <= in_valid;
            c_sh[0] <= is_cw;
            z_sh[0] <= all_zero;
            s_sh[0] <= sgn;
            for (int k = 1; k < NITER; k++) begin
                v_sh[k] <= v_sh[k-1];
                c_sh[k] <= c_sh[k-1];
                z_sh[k] <= z_sh[k-1];
                s_sh[k] <= s_sh[k-1];
            end
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sh[NITER-1]);

    p_codeword_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_sh[NITER-1] && c_sh[NITER-1]) |-> (out_bits == s_sh[NITER-1]));

    p_erasure_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_sh[NITER-1] && z_sh[NITER-1]) |-> (out_bits == s_sh[NITER-1]));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_bits));

endmodule

bind iter_thresh_dec itd_chk #(.Q(Q), .NITER(NITER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .out_bits  (out_bits)
);

// File: tb/iter_thresh_dec_tb_top.sv
module iter_thresh_dec_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q     = 5;
    localparam int NITER = 2;
    localparam int ASH   = 1;
    localparam int N     = 7;
    localparam int MAXM  = (1 << (Q - 1)) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*Q-1:0] in_sym = '0;
    logic           out_valid;
    logic [N-1:0]   out_bits;

    iter_thresh_dec #(.Q(Q), .NITER(NITER), .ASH(ASH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sym    (in_sym),
        .out_valid (out_valid),
        .out_bits  (out_bits)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [N-1:0] last_bits = '0;

    logic [N-1:0] q_bits [$];
    int           q_cyc  [$];
    string        q_tag  [$];
    logic [N-1:0] cw     [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int md(input int a);
        return ((a % N) + N) % N;
    endfunction

    function automatic bit is_cw(input logic [N-1:0] b);
        for (int i = 0; i < N; i++)
            if (b[i] ^ b[md(i+1)] ^ b[md(i+3)]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [N*Q-1:0] sym(input logic [N-1:0] signs, input int m);
        logic [N*Q-1:0] w;
        w = '0;
        for (int i = 0; i < N; i++) w[i*Q +: Q] = {signs[i], (Q-1)'(m)};
        return w;
    endfunction

    // Independent model of the iterations, written from the requirements.
    function automatic logic [N-1:0] ref_dec(input logic [N*Q-1:0] w);
        int r [N];
        int pw[N];
        int y [N];
        int e [N];
        logic [N-1:0] h;
        h = '0;
        for (int i = 0; i < N; i++) begin
            r[i]  = int'(w[i*Q +: Q-1]);
            if (w[i*Q+Q-1]) r[i] = -r[i];
            pw[i] = 0;
        end
        for (int it = 0; it < NITER; it++) begin
            for (int i = 0; i < N; i++) begin
                int a;
                a = ((pw[i] < 0) ? -pw[i] : pw[i]) >> ASH;
                y[i] = r[i] + ((pw[i] < 0) ? -a : a);
                if (y[i] > MAXM) y[i] = MAXM;
                if (y[i] < -MAXM) y[i] = -MAXM;
            end
            for (int i = 0; i < N; i++) begin
                e[i] = 0;
                // lines through i: {i,i+1,i+3}, {i-1,i,i+2}, {i-3,i-2,i}
                for (int l = 0; l < 3; l++) begin
                    int pa, pb, ma, mb, mn;
                    bit ng;
                    pa = (l == 0) ? md(i+1) : (l == 1) ? md(i-1) : md(i-3);
                    pb = (l == 0) ? md(i+3) : (l == 1) ? md(i+2) : md(i-2);
                    ma = (y[pa] < 0) ? -y[pa] : y[pa];
                    mb = (y[pb] < 0) ? -y[pb] : y[pb];
                    mn = (ma < mb) ? ma : mb;
                    ng = (y[pa] < 0) ^ (y[pb] < 0);
                    e[i] = e[i] + (ng ? -mn : mn);
                end
            end
            if (it == NITER - 1) begin
                for (int i = 0; i < N; i++) begin
                    int t;
                    t = y[i] + e[i];
                    h[i] = (t < 0) ? 1'b1 : (t > 0) ? 1'b0 : w[i*Q+Q-1];
                end
            end else begin
                for (int i = 0; i < N; i++) pw[i] = e[i];
            end
        end
        return h;
    endfunction

    task automatic observe();
        if (out_valid) begin
            if (q_bits.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", 1, 0);
            end else begin
                logic [N-1:0] eb;
                int ec;
                string et;
                eb = q_bits.pop_front();
                ec = q_cyc.pop_front();
                et = q_tag.pop_front();
                chk(cyc == ec + NITER, "R2 latency", cyc - ec, NITER);
                chk(out_bits == eb, et, int'(out_bits), int'(eb));
            end
        end else begin
            chk(out_bits == last_bits, "R8 hold while idle", int'(out_bits), int'(last_bits));
            if (q_bits.size() != 0 && cyc > q_cyc[0] + NITER)
                chk(1'b0, "R2 missing result", 0, 1);
        end
        last_bits = out_bits;
    endtask

    task automatic drive(input logic v, input logic [N*Q-1:0] s,
                         input logic [N-1:0] e, input string tag);
        @(negedge clk);
        observe();
        in_valid = v;
        in_sym   = s;
        if (v) begin
            q_bits.push_back(e);
            q_cyc.push_back(cyc);
            q_tag.push_back(tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int w = 0; w < 128; w++)
            if (is_cw(7'(w))) cw.push_back(7'(w));

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
        chk(out_bits == '0, "R9 out_bits in reset", int'(out_bits), 0);
        chk(cw.size() == 8, "R3 codeword count", cw.size(), 8);
        rst_n = 1'b1;

        // R3: codewords with random magnitudes, back to back
        foreach (cw[c]) begin
            logic [N*Q-1:0] s;
            s = '0;
            for (int i = 0; i < N; i++)
                s[i*Q +: Q] = {cw[c][i], (Q-1)'($urandom % (MAXM + 1))};
            drive(1'b1, s, cw[c], "R3 clean codeword");
        end

        // R4: single sign error, uniform magnitude
        foreach (cw[c]) begin
            for (int p = 0; p < N; p++) begin
                logic [N-1:0] f;
                f = cw[c];
                f[p] = ~f[p];
                drive(1'b1, sym(f, 1 + int'($urandom % MAXM)), cw[c], "R4 single error");
            end
        end

        // R1: bit order with erasure words holding one negative-zero symbol
        for (int p = 0; p < N; p++)
            drive(1'b1, sym(7'(1 << p), 0), 7'(1 << p), "R1 bit position");

        // R7: all-magnitude-zero words return their signs
        for (int k = 0; k < 10; k++) begin
            logic [N-1:0] sg;
            sg = 7'($urandom);
            drive(1'b1, sym(sg, 0), sg, "R7 erasure tie");
        end

        // R6: full-scale magnitudes force saturation of the weighted sum
        for (int k = 0; k < 16; k++) begin
            logic [N*Q-1:0] s;
            s = sym(7'($urandom), MAXM);
            drive(1'b1, s, ref_dec(s), "R6 saturation");
        end

        // R5, R6, R8: random words with gaps (idle inputs carry junk)
        for (int k = 0; k < 250; k++) begin
            logic [N*Q-1:0] s;
            logic v;
            s = (N*Q)'({$urandom, $urandom});
            v = ($urandom % 10) < 7;
            drive(v, s, ref_dec(s), "R5,R6 random word");
        end

        for (int k = 0; k < NITER + 3; k++) drive(1'b0, '0, '0, "");
        @(negedge clk);
        observe();
        chk(q_bits.size() == 0, "R2 all results delivered", q_bits.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule